// File: doc/BRIEF.md
# Dual-Channel Buck Gate Sequencer

This block is the digital timing core for two synchronous step-down converter channels. For each channel it decides when the high-side gate (DH) and the low-side gate (DL) switch. It works from three single-bit comparator results: feedback at or under the reference, inductor current crossing zero, and negative current over its limit. All timing is counted in clock cycles of one shared clock.

A switching cycle is a DH pulse with a programmed on-time, a dead gap, then a DL pulse that must last at least a minimum off-time. After that, the event that closes the DL pulse sets what comes next. If feedback closes it, the next DH pulse follows after a second dead gap. If negative current or, in skip mode, a zero crossing closes it, both gates rest low until feedback asks for energy again. A channel enters skip mode after a run of switching cycles that each saw a zero crossing. Each channel runs on its own, with one exception: a channel about to raise DH waits briefly if the other channel has just moved a gate.

Top module: `dual_buck_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `dh`, `dl` and `skip` are 0 on both channels.
- R2: Every DH pulse of channel c lasts max(ton, 1) cycles, where ton is `ton_cfg[c*TON_W +: TON_W]`.
- R3: DH and DL of a channel are never high in the same cycle, and DL rises exactly DEAD_CYC (default 2) cycles after DH falls.
- R4: Once DL rises it stays high for at least MIN_OFF (default 33) cycles while `en` stays high, whatever the sense inputs do.
- R5: When DL is closed because `fb_low` is high, DH rises again after exactly DEAD_CYC low cycles.
- R6: Once the minimum off-time has passed, `ncl` closes DL and takes priority over `zc` and `fb_low`. Both gates then stay low until `fb_low` is sampled high, and DH rises on the next cycle. If `fb_low` is already high, exactly one cycle lies between the DL fall and the DH rise.
- R7: Outside skip mode `zc` never closes DL: with `fb_low` low, DL stays high.
- R8: `skip` rises at the DL fall that completes the ZC_RUN-th (default 8) consecutive switching cycle in which `zc` was high while DL was high. In skip mode, `zc` closes DL once the minimum off-time has passed, with priority over `fb_low`, and both gates stay low until `fb_low` is high.
- R9: A switching cycle whose DL-high period never sees `zc` clears the run count, and `skip`, at its DL fall.
- R10: When a channel decides to start DH (sees `fb_low` while idle, or reaches the end of its post-DL dead gap) in the cycle right after the other channel's DH or DL changed level, its DH rise is delayed by HOLD_CYC (default 3) cycles.
- R11: With `en` low, a channel's gates are low from the next cycle, its state and counters reset, and its `skip` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all timing |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 2 | Per-channel run enable, bit c for channel c |
| fb_low | input | 2 | Feedback at or below reference, per channel |
| zc | input | 2 | Zero-crossing comparator output, per channel |
| ncl | input | 2 | Negative current limit comparator output, per channel |
| ton_cfg | input | 2*TON_W | On-time in cycles, channel c at bits c*TON_W and up |
| dh | output | 2 | High-side gate command per channel |
| dl | output | 2 | Low-side gate command per channel |
| skip | output | 2 | Light-load skip mode active, per channel |

## Verification
The checker watches every cycle for gate overlap, for a DL rise that follows DH too closely, for DL pulses shorter than the minimum off-time, for gates left high after an enable drop, and for skip mode turning on anywhere except at a DL fall. Exact pulse and gap lengths, the order in which closing events take priority, the run of eight zero-crossing cycles, the clearing of that run, and the hold-off interplay between the two channels need stimulus sequences. Only the bench's scenarios can show those, by measuring widths and delays at the ports.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    localparam int NCH = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_ON,
        PH_DEAD_HL,
        PH_LOW,
        PH_DEAD_LH
    } phase_e;

    typedef struct packed {
        logic fb_low;
        logic zc;
        logic ncl;
    } sense_t;

    typedef enum logic [1:0] {
        END_NONE,
        END_FB,
        END_ZC,
        END_NCL
    } low_end_e;

    // Which event closes the low-side pulse once the minimum off-time is over.
    function automatic low_end_e pick_end(sense_t s, logic skip_on);
        if (s.ncl)
            return END_NCL;
        else if (skip_on && s.zc)
            return END_ZC;
        else if (s.fb_low)
            return END_FB;
        else
            return END_NONE;
    endfunction

    // Counter width big enough for every timed phase.
    function automatic int cnt_width(int ton_w, int min_off, int dead, int hold);
        int m;
        m = (1 << ton_w) - 1;
        if (min_off > m) m = min_off;
        if (dead > m) m = dead;
        if (hold > m) m = hold;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/buck_timer.sv
module buck_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/buck_zc_track.sv
module buck_zc_track #(
    parameter int ZC_RUN = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic low_start,
    input  logic low_active,
    input  logic low_exit,
    input  logic zc,
    output logic skip
);
    localparam int RW = $clog2(ZC_RUN + 1);

    logic          seen;
    logic [RW-1:0] run;
    logic          hit;

    assign hit = seen | zc;

    always_ff @(posedge clk) begin
        if (clr)
            seen <= 1'b0;
        else if (low_start)
            seen <= 1'b0;
        else if (low_active && zc)
            seen <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            run  <= '0;
            skip <= 1'b0;
        end else if (low_exit) begin
            if (hit) begin
                if (run < RW'(ZC_RUN))
                    run <= run + RW'(1);
                if (run >= RW'(ZC_RUN - 1))
                    skip <= 1'b1;
            end else begin
                run  <= '0;
                skip <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/buck_chan.sv
module buck_chan
    import buck_seq_pkg::*;
#(
    parameter int TON_W    = 8,
    parameter int MIN_OFF  = 33,
    parameter int DEAD_CYC = 2,
    parameter int HOLD_CYC = 3,
    parameter int ZC_RUN   = 8,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  sense_t           sense,
    input  logic [TON_W-1:0] ton,
    input  logic             peer_chg,
    output logic             dh,
    output logic             dl,
    output logic             skip,
    output logic             gate_chg
);
    localparam logic [CNT_W-1:0] MIN_LD  = CNT_W'(MIN_OFF - 1);
    localparam logic [CNT_W-1:0] DEAD_LD = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);

    phase_e           st, nxt;
    logic             clr;
    logic             ld;
    logic [CNT_W-1:0] ldv;
    logic             done;
    logic             low_start, low_exit;
    logic [CNT_W-1:0] ton_ld;
    logic             dh_q, dl_q;
    low_end_e         end_kind;

    assign clr    = rst | ~en;
    assign ton_ld = (ton == '0) ? '0 : CNT_W'(ton - TON_W'(1));
    assign end_kind = pick_end(sense, skip);

    always_comb begin
        nxt       = st;
        ld        = 1'b0;
        ldv       = '0;
        low_start = 1'b0;
        low_exit  = 1'b0;
        case (st)
            PH_IDLE: begin
                if (sense.fb_low) begin
                    ld = 1'b1;
                    if (peer_chg) begin
                        nxt = PH_HOLD;
                        ldv = HOLD_LD;
                    end else begin
                        nxt = PH_ON;
                        ldv = ton_ld;
                    end
                end
            end
            PH_HOLD: begin
                if (done) begin
                    nxt = PH_ON;
                    ld  = 1'b1;
                    ldv = ton_ld;
                end
            end
            PH_ON: begin
                if (done) begin
                    nxt = PH_DEAD_HL;
                    ld  = 1'b1;
                    ldv = DEAD_LD;
                end
            end
            PH_DEAD_HL: begin
                if (done) begin
                    nxt       = PH_LOW;
                    ld        = 1'b1;
                    ldv       = MIN_LD;
                    low_start = 1'b1;
                end
            end
            PH_LOW: begin
                if (done) begin
                    case (end_kind)
                        END_NCL, END_ZC: begin
                            nxt      = PH_IDLE;
                            low_exit = 1'b1;
                        end
                        END_FB: begin
                            nxt      = PH_DEAD_LH;
                            ld       = 1'b1;
                            ldv      = DEAD_LD;
                            low_exit = 1'b1;
                        end
                        default: nxt = PH_LOW;
                    endcase
                end
            end
            PH_DEAD_LH: begin
                if (done) begin
                    ld = 1'b1;
                    if (peer_chg) begin
                        nxt = PH_HOLD;
                        ldv = HOLD_LD;
                    end else begin
                        nxt = PH_ON;
                        ldv = ton_ld;
                    end
                end
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr)
            st <= PH_IDLE;
        else
            st <= nxt;
    end

    buck_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .clr      (clr),
        .load     (ld),
        .load_val (ldv),
        .done     (done)
    );

    buck_zc_track #(.ZC_RUN(ZC_RUN)) u_zc (
        .clk        (clk),
        .clr        (clr),
        .low_start  (low_start),
        .low_active (st == PH_LOW),
        .low_exit   (low_exit),
        .zc         (sense.zc),
        .skip       (skip)
    );

    assign dh = (st == PH_ON);
    assign dl = (st == PH_LOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            dh_q <= 1'b0;
            dl_q <= 1'b0;
        end else begin
            dh_q <= dh;
            dl_q <= dl;
        end
    end

    assign gate_chg = (dh ^ dh_q) | (dl ^ dl_q);
endmodule

// File: rtl/dual_buck_seq.sv
module dual_buck_seq
    import buck_seq_pkg::*;
#(
    parameter int TON_W    = 8,
    parameter int MIN_OFF  = 33,
    parameter int DEAD_CYC = 2,
    parameter int HOLD_CYC = 3,
    parameter int ZC_RUN   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       en,
    input  logic [NCH-1:0]       fb_low,
    input  logic [NCH-1:0]       zc,
    input  logic [NCH-1:0]       ncl,
    input  logic [NCH*TON_W-1:0] ton_cfg,
    output logic [NCH-1:0]       dh,
    output logic [NCH-1:0]       dl,
    output logic [NCH-1:0]       skip
);
    localparam int CNT_W = cnt_width(TON_W, MIN_OFF, DEAD_CYC, HOLD_CYC);

    logic [NCH-1:0] chg;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sense_t s;
        logic   peer;

        assign s    = '{fb_low: fb_low[c], zc: zc[c], ncl: ncl[c]};
        assign peer = |(chg & ~(NCH'(1) << c));

        buck_chan #(
            .TON_W    (TON_W),
            .MIN_OFF  (MIN_OFF),
            .DEAD_CYC (DEAD_CYC),
            .HOLD_CYC (HOLD_CYC),
            .ZC_RUN   (ZC_RUN),
            .CNT_W    (CNT_W)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .en       (en[c]),
            .sense    (s),
            .ton      (ton_cfg[c*TON_W +: TON_W]),
            .peer_chg (peer),
            .dh       (dh[c]),
            .dl       (dl[c]),
            .skip     (skip[c]),
            .gate_chg (chg[c])
        );
    end
endmodule

// File: rtl/dual_buck_seq_chk.sv
module dual_buck_seq_chk
    import buck_seq_pkg::*;
#(
    parameter int MIN_OFF = 33
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] en,
    input logic [NCH-1:0] dh,
    input logic [NCH-1:0] dl,
    input logic [NCH-1:0] skip
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic [15:0] dl_run;

        always_ff @(posedge clk) begin
            if (rst)
                dl_run <= '0;
            else if (dl[c])
                dl_run <= (dl_run == 16'hFFFF) ? dl_run : dl_run + 16'd1;
            else
                dl_run <= '0;
        end

        AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
            !(dh[c] && dl[c])); // R3

        AST_DL_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
            $rose(dl[c]) |-> !$past(dh[c])); // R3

        AST_MIN_OFF: assert property (@(posedge clk) disable iff (rst)
            ($fell(dl[c]) && $past(en[c])) |-> (dl_run >= 16'(MIN_OFF))); // R4

        AST_EN_OFF: assert property (@(posedge clk) disable iff (rst)
            !en[c] |=> (!dh[c] && !dl[c] && !skip[c])); // R11

        AST_SKIP_AT_FALL: assert property (@(posedge clk) disable iff (rst)
            $rose(skip[c]) |-> $fell(dl[c])); // R8
    end
endmodule

bind dual_buck_seq dual_buck_seq_chk #(.MIN_OFF(MIN_OFF)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .dh   (dh),
    .dl   (dl),
    .skip (skip)
);

// File: tb/dual_buck_seq_test.sv
module dual_buck_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int TON_W      = 8;
    localparam int MIN_OFF    = 33;
    localparam int DEAD_CYC   = 2;
    localparam int HOLD_CYC   = 3;
    localparam int ZC_RUN     = 8;
    localparam int WATCHDOG   = 150000;
    localparam int NROWS      = 5;
    localparam int TON_TAB [NROWS] = '{1, 5, 12, 0, 40};

    logic                 clk = 1'b0;
    logic                 rst;
    logic [1:0]           en, fb_low, zc, ncl;
    logic [2*TON_W-1:0]   ton_cfg;
    logic [1:0]           dh, dl, skip;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_buck_seq #(
        .TON_W(TON_W), .MIN_OFF(MIN_OFF), .DEAD_CYC(DEAD_CYC),
        .HOLD_CYC(HOLD_CYC), .ZC_RUN(ZC_RUN)
    ) uut (
        .clk(clk), .rst(rst), .en(en), .fb_low(fb_low), .zc(zc), .ncl(ncl),
        .ton_cfg(ton_cfg), .dh(dh), .dl(dl), .skip(skip)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 2'b00; fb_low = 2'b00; zc = 2'b00; ncl = 2'b00;
        ton_cfg = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic measure(input int c, output int w_dh, output int g_hl,
                           output int w_dl, output int g_lh);
        int g;
        g = 0;
        while (!dh[c] && g < 2000) begin @(negedge clk); g++; end
        w_dh = 0;
        while (dh[c] && w_dh < 2000) begin w_dh++; @(negedge clk); end
        g_hl = 0;
        while (!dl[c] && g_hl < 2000) begin g_hl++; @(negedge clk); end
        w_dl = 0;
        while (dl[c] && w_dl < 2000) begin w_dl++; @(negedge clk); end
        g_lh = 0;
        while (!dh[c] && g_lh < 2000) begin g_lh++; @(negedge clk); end
    endtask

    task automatic wait_dl_fall(input int c);
        int g;
        g = 0;
        while (!dl[c] && g < 2000) begin @(negedge clk); g++; end
        while (dl[c] && g < 4000) begin @(negedge clk); g++; end
    endtask

    task automatic count_high(input int c, input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (dh[c] || dl[c]) hits++;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int w_dh, g_hl, w_dl, g_lh, hits, n, exp_dh;

        rst = 1'b1; en = 2'b00; fb_low = 2'b00; zc = 2'b00; ncl = 2'b00;
        ton_cfg = '0;
        repeat (3) @(negedge clk);
        check("R1", "dh in reset", int'(dh), 0);
        check("R1", "dl in reset", int'(dl), 0);
        check("R1", "skip in reset", int'(skip), 0);
        en = 2'b11; fb_low = 2'b11;
        rst = 1'b0;
        check("R1", "gates after reset release", int'({dh, dl, skip}), 0);

        // Heavy-load vector table: fb_low held high, channel 0 alone
        for (int i = 0; i < NROWS; i++) begin
            do_reset();
            ton_cfg[TON_W-1:0] = TON_TAB[i][TON_W-1:0];
            en = 2'b01; fb_low = 2'b01;
            exp_dh = (TON_TAB[i] == 0) ? 1 : TON_TAB[i];
            measure(0, w_dh, g_hl, w_dl, g_lh);
            check("R2", "DH width", w_dh, exp_dh);
            check("R3", "DH-fall to DL-rise gap", g_hl, DEAD_CYC);
            check("R4", "DL width under constant fb_low", w_dl, MIN_OFF);
            check("R5", "DL-fall to DH-rise gap", g_lh, DEAD_CYC);
        end

        // R7: zero-cross outside skip mode does not end DL
        do_reset();
        ton_cfg[TON_W-1:0] = 8'd4; en = 2'b01; fb_low = 2'b01;
        while (!dl[0]) @(negedge clk);
        fb_low = 2'b00; zc = 2'b01;
        repeat (60) @(negedge clk);
        check("R7", "DL still high with zc and no fb", int'(dl[0]), 1);

        // R6: negative current limit
        do_reset();
        ton_cfg[TON_W-1:0] = 8'd4; en = 2'b01; fb_low = 2'b01;
        while (!dl[0]) @(negedge clk);
        ncl = 2'b01; fb_low = 2'b00;
        n = 0;
        while (dl[0] && n < 2000) begin n++; @(negedge clk); end
        check("R4", "DL width with ncl from rise", n, MIN_OFF);
        ncl = 2'b00;
        count_high(0, 30, hits);
        check("R6", "gates idle after ncl until fb", hits, 0);
        fb_low = 2'b01;
        @(negedge clk);
        check("R6", "DH one cycle after fb_low", int'(dh[0]), 1);
        while (!dl[0]) @(negedge clk);
        ncl = 2'b01;
        while (dl[0]) @(negedge clk);
        ncl = 2'b00;
        n = 0;
        while (!dh[0] && n < 2000) begin n++; @(negedge clk); end
        check("R6", "ncl beats fb: DL-fall to DH-rise gap", n, 1);

        // R8 / R9: skip mode entry, zero-cross end, clearing
        do_reset();
        ton_cfg[TON_W-1:0] = 8'd4; en = 2'b01; fb_low = 2'b01; zc = 2'b01;
        for (int k = 1; k <= ZC_RUN; k++) begin
            wait_dl_fall(0);
            if (k >= ZC_RUN - 1)
                check("R8", $sformatf("skip after zc cycle %0d", k),
                      int'(skip[0]), (k >= ZC_RUN) ? 1 : 0);
        end
        measure(0, w_dh, g_hl, w_dl, g_lh);
        check("R8", "zc ends DL in skip: gap to DH", g_lh, 1);
        check("R4", "DL width in skip mode", w_dl, MIN_OFF);
        fb_low = 2'b00;
        wait_dl_fall(0);
        count_high(0, 30, hits);
        check("R8", "gates idle after zc end until fb", hits, 0);
        zc = 2'b00; fb_low = 2'b01;
        wait_dl_fall(0);
        check("R9", "skip cleared after cycle without zc", int'(skip[0]), 0);

        // R11: enable drop clears skip and gates
        do_reset();
        ton_cfg[TON_W-1:0] = 8'd4; en = 2'b01; fb_low = 2'b01; zc = 2'b01;
        for (int k = 1; k <= ZC_RUN; k++) wait_dl_fall(0);
        check("R8", "skip set before enable drop", int'(skip[0]), 1);
        while (!dl[0]) @(negedge clk);
        en = 2'b00;
        @(negedge clk);
        check("R11", "gates and skip after en low", int'({dh[0], dl[0], skip[0]}), 0);
        count_high(0, 20, hits);
        check("R11", "gates stay low while disabled", hits, 0);

        // R10: hold-off when the other channel has just switched
        do_reset();
        ton_cfg = {8'd5, 8'd20}; en = 2'b11;
        fb_low = 2'b01;
        while (!dh[0]) @(negedge clk);
        fb_low = 2'b11;
        n = 0;
        do begin @(negedge clk); n++; end while (!dh[1] && n < 50);
        check("R10", "DH1 delay with channel 0 edge", n, 1 + HOLD_CYC);

        do_reset();
        ton_cfg = {8'd5, 8'd20}; en = 2'b11;
        fb_low = 2'b01;
        while (!dh[0]) @(negedge clk);
        repeat (5) @(negedge clk);
        fb_low = 2'b11;
        n = 0;
        do begin @(negedge clk); n++; end while (!dh[1] && n < 50);
        check("R10", "DH1 delay with channel 0 quiet", n, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule